// File: doc/BRIEF.md
# Multicast Snooping Packet Receiver

This block sits at a slave port of a shared bus segment and watches every packet that crosses the segment. A packet starts with a header made of the sender's identifier, the sender's opcode and a list of destination entries. Each destination entry pairs a receiver identifier with an opcode for that receiver. The payload words follow the header. One transfer on the bus can therefore reach several receivers at once. Every receiver looks for its own identifier in the destination list and copies the payload only when it finds it.

The receiver counts words from the first cycle in which the grant is high. It compares each destination entry with its local identifier and also with the all-ones broadcast code. When an entry hits, the receiver sets its acquire flag. It keeps reading the rest of the header, because one packet may give the same receiver several opcodes, and it stores the opcode of every entry that hits. Once the header has ended, each payload word produces a read strobe together with the captured word, and a payload counter increases by one. When the grant falls, all per-packet state clears.

The number of destination entries comes in on an input and must stay stable while the grant is high. The local identifier must never be the all-ones value.

Top module: `mc_snoop_rx`

## Requirements
- R1: While reset is high and in the cycle after it, acquire, rd_strobe, rd_data, op_list, op_count and pay_cnt are all zero.
- R2: Word layout of a packet: word 0 is the sender identifier and word 1 is the sender opcode. Words 2 to 1+dest_count are destination entries, with the identifier in bus_data[OP_W+ID_W-1:OP_W] (bits 7:4 by default) and the opcode in bus_data[OP_W-1:0]. All later words are payload. The first two words never count as a hit, even when they hold the local identifier.
- R3: acquire rises on the clock edge that samples the first destination entry whose identifier hits. It stays high until the grant falls.
- R4: A destination identifier of all ones hits in every receiver.
- R5: Every destination entry that hits appends its opcode to op_list in the order it arrives. Slot i sits at op_list[i*OP_W +: OP_W]. Unused slots read zero, and op_count gives the number of filled slots.
- R6: With acquire high, each payload word sampled while the grant is high gives rd_strobe high for one cycle after that edge, with rd_data equal to the word.
- R7: A packet that has no hitting entry leaves acquire, rd_strobe, op_count and pay_cnt at zero for the whole packet.
- R8: pay_cnt increases by one with each rd_strobe in a packet, so at the end of a packet it equals the number of payload words received.
- R9: On the first edge at which the grant is low, acquire, rd_strobe, op_list, op_count and pay_cnt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | High for every cycle of a packet on the segment; one word per cycle |
| bus_data | input | DATA_W | Segment data bus |
| dest_count | input | DCNT_W | Number of destination entries in the header, 1 to MAX_DEST |
| local_id | input | ID_W | Identifier of this receiver, never all ones |
| acquire | output | 1 | This receiver is addressed by the current packet |
| rd_strobe | output | 1 | A payload word has been captured |
| rd_data | output | DATA_W | The captured payload word |
| op_list | output | MAX_DEST*OP_W | Opcodes collected from hitting entries, slot 0 in the low bits |
| op_count | output | OCNT_W | Number of filled opcode slots |
| pay_cnt | output | PCNT_W | Payload words captured in this packet |

## Verification
The sweep covers every legal local identifier, every destination count from one to the maximum, four patterns of destination identifiers and payload lengths of one to three words. Patterns with no hit tell apart receivers that must stay silent from those that must capture. A single direct hit checks acquire timing and capture. A direct hit together with a broadcast entry checks multi-opcode collection and slot order. Every sender word carries the local identifier in the entry identifier field, so a design that also decodes the first two words as destinations would show extra opcodes.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [1:0] {
    WK_SRC = 2'd0,
    WK_SOP = 2'd1,
    WK_DST = 2'd2,
    WK_PAY = 2'd3
  } word_kind_t;
endpackage

// File: rtl/msr_phase.sv
module msr_phase #(
  parameter int MAX_DEST = 4,
  localparam int DCNT_W = $clog2(MAX_DEST + 1),
  localparam int POS_W  = $clog2(MAX_DEST + 3)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       grant,
  input  logic [DCNT_W-1:0]          dest_count,
  output msr_pkg::word_kind_t        kind
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] hdr_len;

  assign hdr_len = POS_W'(dest_count) + POS_W'(2);

  always_ff @(posedge clk) begin
    if (rst || !grant) pos <= '0;
    else if (pos < hdr_len) pos <= pos + POS_W'(1);
  end

  always_comb begin
    if (pos == POS_W'(0))      kind = msr_pkg::WK_SRC;
    else if (pos == POS_W'(1)) kind = msr_pkg::WK_SOP;
    else if (pos < hdr_len)    kind = msr_pkg::WK_DST;
    else                       kind = msr_pkg::WK_PAY;
  end
endmodule

// File: rtl/msr_match.sv
module msr_match #(
  parameter int ID_W = 4
) (
  input  logic [ID_W-1:0] entry_id,
  input  logic [ID_W-1:0] local_id,
  output logic            hit
);
  localparam logic [ID_W-1:0] BCAST = '1;
  assign hit = (entry_id == local_id) || (entry_id == BCAST);
endmodule

// File: rtl/msr_collect.sv
module msr_collect #(
  parameter int MAX_DEST = 4,
  parameter int OP_W     = 4,
  localparam int OCNT_W  = $clog2(MAX_DEST + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     grant,
  input  logic                     take,
  input  logic [OP_W-1:0]          op_in,
  output logic                     acquire,
  output logic [MAX_DEST*OP_W-1:0] op_list,
  output logic [OCNT_W-1:0]        op_count
);
  logic room;
  assign room = (op_count < OCNT_W'(MAX_DEST));

  always_ff @(posedge clk) begin
    if (rst || !grant) begin
      acquire  <= 1'b0;
      op_count <= '0;
    end else if (take) begin
      acquire <= 1'b1;
      if (room) op_count <= op_count + OCNT_W'(1);
    end
  end

  for (genvar i = 0; i < MAX_DEST; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || !grant)
        op_list[i*OP_W +: OP_W] <= '0;
      else if (take && op_count == OCNT_W'(i))
        op_list[i*OP_W +: OP_W] <= op_in;
    end
  end
endmodule

// File: rtl/msr_capture.sv
module msr_capture #(
  parameter int DATA_W = 16,
  parameter int PCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              in_payload,
  input  logic              acquire,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic [PCNT_W-1:0] pay_cnt
);
  logic grab;
  assign grab = grant && in_payload && acquire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_strobe <= 1'b0;
      rd_data   <= '0;
      pay_cnt   <= '0;
    end else begin
      rd_strobe <= grab;
      if (grab) begin
        rd_data <= bus_data;
        pay_cnt <= pay_cnt + PCNT_W'(1);
      end else if (!grant) begin
        pay_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/mc_snoop_rx.sv
module mc_snoop_rx #(
  parameter int MAX_DEST = 4,
  parameter int ID_W     = 4,
  parameter int OP_W     = 4,
  parameter int DATA_W   = 16,
  parameter int PCNT_W   = 8,
  localparam int DCNT_W  = $clog2(MAX_DEST + 1),
  localparam int OCNT_W  = $clog2(MAX_DEST + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     grant,
  input  logic [DATA_W-1:0]        bus_data,
  input  logic [DCNT_W-1:0]        dest_count,
  input  logic [ID_W-1:0]          local_id,
  output logic                     acquire,
  output logic                     rd_strobe,
  output logic [DATA_W-1:0]        rd_data,
  output logic [MAX_DEST*OP_W-1:0] op_list,
  output logic [OCNT_W-1:0]        op_count,
  output logic [PCNT_W-1:0]        pay_cnt
);
  msr_pkg::word_kind_t kind;
  logic [ID_W-1:0] entry_id;
  logic [OP_W-1:0] entry_op;
  logic            hit;
  logic            take;

  assign entry_id = bus_data[OP_W +: ID_W];
  assign entry_op = bus_data[OP_W-1:0];
  assign take     = grant && (kind == msr_pkg::WK_DST) && hit;

  msr_phase #(.MAX_DEST(MAX_DEST)) u_phase (
    .clk(clk), .rst(rst), .grant(grant), .dest_count(dest_count), .kind(kind)
  );

  msr_match #(.ID_W(ID_W)) u_match (
    .entry_id(entry_id), .local_id(local_id), .hit(hit)
  );

  msr_collect #(.MAX_DEST(MAX_DEST), .OP_W(OP_W)) u_collect (
    .clk(clk), .rst(rst), .grant(grant), .take(take), .op_in(entry_op),
    .acquire(acquire), .op_list(op_list), .op_count(op_count)
  );

  msr_capture #(.DATA_W(DATA_W), .PCNT_W(PCNT_W)) u_capture (
    .clk(clk), .rst(rst), .grant(grant), .in_payload(kind == msr_pkg::WK_PAY),
    .acquire(acquire), .bus_data(bus_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .pay_cnt(pay_cnt)
  );
endmodule

// File: rtl/mc_snoop_rx_checker.sv
module mc_snoop_rx_checker #(
  parameter int MAX_DEST = 4,
  parameter int OP_W     = 4,
  parameter int PCNT_W   = 8,
  localparam int OCNT_W  = $clog2(MAX_DEST + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              grant,
  input logic              acquire,
  input logic              rd_strobe,
  input logic [OCNT_W-1:0] op_count,
  input logic [PCNT_W-1:0] pay_cnt
);
  // R6: a capture only happens for an addressed receiver
  assert_strobe_needs_acquire_R6: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> acquire);

  // R9: a low grant clears the per-packet state on the next edge
  assert_clear_on_release_R9: assert property (@(posedge clk) disable iff (rst)
    !grant |=> (!acquire && !rd_strobe && op_count == '0 && pay_cnt == '0));

  // R3: acquire rises together with the first stored opcode
  assert_first_hit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(acquire) |-> op_count == OCNT_W'(1));

  // R5: the opcode slot count never passes the list size
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    op_count <= OCNT_W'(MAX_DEST));

  // R8: every strobe adds exactly one to the payload count
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> pay_cnt == $past(pay_cnt) + PCNT_W'(1));

  // R1: all outputs at rest right after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!acquire && !rd_strobe && op_count == '0 && pay_cnt == '0));
endmodule

bind mc_snoop_rx mc_snoop_rx_checker #(
  .MAX_DEST(MAX_DEST), .OP_W(OP_W), .PCNT_W(PCNT_W)
) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .acquire(acquire),
  .rd_strobe(rd_strobe), .op_count(op_count), .pay_cnt(pay_cnt)
);

// File: tb/mc_snoop_rx_tb.sv
module mc_snoop_rx_tb;
  localparam int CLK_P    = 10;
  localparam int MAX_DEST = 4;
  localparam int ID_W     = 4;
  localparam int OP_W     = 4;
  localparam int DATA_W   = 16;
  localparam int PCNT_W   = 8;
  localparam int DCNT_W   = $clog2(MAX_DEST + 1);
  localparam int OCNT_W   = $clog2(MAX_DEST + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic [DATA_W-1:0] bus_data = '0;
  logic [DCNT_W-1:0] dest_count = DCNT_W'(1);
  logic [ID_W-1:0]   local_id = '0;
  logic acquire, rd_strobe;
  logic [DATA_W-1:0] rd_data;
  logic [MAX_DEST*OP_W-1:0] op_list;
  logic [OCNT_W-1:0] op_count;
  logic [PCNT_W-1:0] pay_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mc_snoop_rx #(.MAX_DEST(MAX_DEST), .ID_W(ID_W), .OP_W(OP_W),
                .DATA_W(DATA_W), .PCNT_W(PCNT_W)) u_dut (
    .clk(clk), .rst(rst), .grant(grant), .bus_data(bus_data),
    .dest_count(dest_count), .local_id(local_id), .acquire(acquire),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .op_list(op_list),
    .op_count(op_count), .pay_cnt(pay_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_packet(input int lid, input int nd, input int seed);
    logic [DATA_W-1:0] w [0:15];
    logic [MAX_DEST*OP_W-1:0] exp_ops;
    int nw, plen, hdr, nhit;
    plen = 1 + (seed + nd) % 3;
    hdr = 2 + nd;
    nw = hdr + plen;
    exp_ops = '0;
    nhit = 0;
    // R2: sender words carry the local id in the entry id field
    w[0] = DATA_W'((lid << OP_W) | lid);
    w[1] = DATA_W'((lid << OP_W) | 4'hF);
    for (int k = 0; k < nd; k++) begin
      int id, op;
      if ((seed + k) % 4 == 0) id = lid;
      else if (seed == 3 && k == 0) id = 15;
      else id = (lid + 1 + k + seed) % 15;
      op = (seed * 5 + k * 3 + 1) % 16;
      w[2+k] = DATA_W'((id << OP_W) | op);
      if (id == lid || id == 15) begin
        exp_ops[nhit*OP_W +: OP_W] = OP_W'(op);
        nhit++;
      end
    end
    for (int q = 0; q < plen; q++)
      w[hdr+q] = DATA_W'(16'hA000 + seed * 256 + lid * 16 + q);

    local_id = ID_W'(lid);
    dest_count = DCNT_W'(nd);
    for (int j = 0; j <= nw; j++) begin
      @(negedge clk);
      if (j > 0) begin
        bit pay;
        pay = (j - 1) >= hdr;
        // R6 / R7: strobe only for payload of an addressed receiver
        chk(rd_strobe == (pay && nhit > 0), "R6/R7 rd_strobe", 64'(rd_strobe),
            64'(pay && nhit > 0));
        if (pay && nhit > 0)
          chk(rd_data == w[j-1], "R6 rd_data", 64'(rd_data), 64'(w[j-1]));
      end
      if (j == hdr)
        chk(acquire == (nhit > 0), "R3/R4 acquire after header", 64'(acquire),
            64'(nhit > 0));
      if (j == nw) begin
        chk(op_list == exp_ops, "R2/R5 op_list", 64'(op_list), 64'(exp_ops));
        chk(op_count == OCNT_W'(nhit), "R5 op_count", 64'(op_count), 64'(nhit));
        chk(pay_cnt == PCNT_W'(nhit > 0 ? plen : 0), "R7/R8 pay_cnt",
            64'(pay_cnt), 64'(nhit > 0 ? plen : 0));
        chk(acquire == (nhit > 0), "R3 acquire held", 64'(acquire), 64'(nhit > 0));
        grant = 1'b0;
        bus_data = '0;
      end else begin
        grant = 1'b1;
        bus_data = w[j];
      end
    end
    @(negedge clk);
    chk(!acquire && !rd_strobe && op_count == '0 && op_list == '0 && pay_cnt == '0,
        "R9 clear after release", {acquire, rd_strobe, op_count, pay_cnt},
        64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!acquire && !rd_strobe && rd_data == '0 && op_list == '0 &&
        op_count == '0 && pay_cnt == '0, "R1 reset state",
        {acquire, rd_strobe, rd_data, op_count}, 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!acquire && !rd_strobe && pay_cnt == '0, "R1 after reset",
        {acquire, rd_strobe, pay_cnt}, 64'(0));
    for (int lid = 0; lid < 15; lid++)
      for (int nd = 1; nd <= MAX_DEST; nd++)
        for (int seed = 0; seed < 4; seed++)
          send_packet(lid, nd, seed);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule